// File: doc/BRIEF.md
# SIMD Modified-Immediate Execution Unit

This unit executes the vector modified-immediate instruction class. It takes a 32-bit instruction word and the current 128-bit contents of the destination vector register. It checks that the word belongs to the class and pulls out the 8-bit immediate, the cmode selector, the op bit, the width bit Q and the destination index. The 8-bit immediate is expanded into a 64-bit pattern, and that pattern is replicated up to the vector width.

Four operations are supported: move, move-inverted, OR into the operand, and AND-NOT against the operand. The operation and the lane shape are not taken from a separate opcode field. They come from a joint decode of cmode and op, and any shift amount is packed into cmode as well.

A surrounding pipeline pulses a valid strobe and receives the result one clock later. The result comes back with a write-enable, an undefined-encoding flag and the destination index. The latency is fixed and does not depend on any data value.

Top module: `simdImmUnit`

## Requirements
- R1: A pulse on `inValid` is captured at a rising edge, and `resValid`, `resWrEn`, `resUndef`, `resDest` and `resData` are presented after exactly that edge. `resValid` is low in any cycle after an edge where `inValid` was low. Reset clears `resValid`, `resWrEn`, `resUndef` and `resData`. The latency is the same for every operand and immediate value.
- R2: The word is in the class only when bit 31 is 0, bits 28:19 equal 0111100000 and bits 11:10 equal 01. Any other word raises `resUndef` and keeps `resWrEn` low.
- R3: Field positions are fixed as follows. Q is bit 30 and op is bit 29. imm8[7:5] sits in bits 18:16 and imm8[4:0] in bits 9:5. cmode is bits 15:12 and the destination index is bits 4:0. The destination index is returned on `resDest`.
- R4: cmode 0xx0 and 0xx1 build 32-bit lanes. Each lane is imm8 shifted left by 8 times cmode[2:1], with the other bits zero.
- R5: cmode 10x0 and 10x1 build 16-bit lanes. Each lane is imm8 shifted left by 8 times cmode[1].
- R6: cmode 110x builds 32-bit lanes with ones filled below imm8. cmode 1100 places imm8 at bits 15:8 over 0xFF. cmode 1101 places imm8 at bits 23:16 over 0xFFFF. All higher bits are zero.
- R7: cmode 1110 with op 0 copies imm8 into every byte of the 64-bit pattern. With op 1, byte i of the pattern is 0xFF when imm8[i] is 1 and 0x00 otherwise.
- R8: cmode 1111 with op 0 builds 32-bit lanes equal to {a, ~b, b repeated 5 times, imm8[5:0], 19 zeros}. cmode 1111 with op 1 and Q 1 builds the 64-bit pattern {a, ~b, b repeated 8 times, imm8[5:0], 48 zeros}. Here a = imm8[7] and b = imm8[6].
- R9: With op 0, an odd cmode below 1100 ORs the replicated pattern into the operand.
- R10: With op 1, an odd cmode below 1100 writes the operand ANDed with the inverted pattern.
- R11: With op 0, every other cmode writes the pattern itself, and the operand has no effect. With op 1, even cmode below 1100 and cmode 110x write the inverted pattern. With op 1, cmode 1110 and 1111 write the pattern itself. In all of these cases the operand has no effect.
- R12: With Q 1 the 64-bit pattern fills both halves. With Q 0, bits 127:64 of the result are zero for every operation.
- R13: cmode 1111 with op 1 and Q 0 is undefined. `resUndef` rises and `resWrEn` stays low. `resData` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: instruction and operand are present |
| instrWord | input | 32 | Instruction word |
| operand | input | 128 | Current destination register value |
| resValid | output | 1 | Result slot is occupied this cycle |
| resWrEn | output | 1 | Write the result to the register file |
| resUndef | output | 1 | Encoding is undefined |
| resDest | output | 5 | Destination register index |
| resData | output | 128 | Result vector |

## Verification
Some behaviours are checked by the embedded assertions on every cycle:
- the one-cycle valid relation;
- that write-enable and the undefined flag exclude each other;
- that an OR result covers the captured operand, and that an AND-NOT result clears every operand bit the pattern does not keep;
- that a narrow result has a zero upper half;
- that data holds on an undefined encoding.

The exact expanded bit patterns for each cmode, the correct choice of operation for each cmode:op pair, and the fact that a move ignores the operand can only be shown by the bench. The bench sweeps every cmode, op and Q against several immediates and operands and compares each result with an independently computed value.

// File: rtl/simdImmPkg.sv
package simdImmPkg;
  localparam int VEC_BITS = 128;
  localparam int PAT_BITS = 64;
  localparam int REPL     = VEC_BITS / PAT_BITS;
  localparam int IMM_BITS = 8;
  localparam int BYTES    = PAT_BITS / 8;
  localparam int DEST_BITS = 5;

  typedef enum logic [1:0] {
    OP_MOVE    = 2'd0,
    OP_MOVEINV = 2'd1,
    OP_OR      = 2'd2,
    OP_ANDNOT  = 2'd3
  } immOp_e;

  typedef struct packed {
    logic   capture;
    immOp_e kind;
    logic   fullWidth;
  } ctrlStrobes_t;
endpackage

// File: rtl/simdImmCtrl.sv
module simdImmCtrl
  import simdImmPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [31:0]  instrWord,
  output ctrlStrobes_t strb,
  output logic         resValid,
  output logic         resUndef,
  output logic         resWrEn
);
  logic [3:0] cmode;
  logic       opBit;
  logic       qBit;
  logic       classOk;
  logic       reserved;
  logic       undefNow;
  immOp_e     kind;

  assign cmode = instrWord[15:12];
  assign opBit = instrWord[29];
  assign qBit  = instrWord[30];

  // Fixed bits that identify the modified-immediate class
  assign classOk  = (instrWord[31] == 1'b0) &&
                    (instrWord[28:19] == 10'b0111100000) &&
                    (instrWord[11:10] == 2'b01);
  assign reserved = (cmode == 4'hF) && opBit && !qBit;
  assign undefNow = !classOk || reserved;

  // Joint cmode:op decode
  always_comb begin
    kind = OP_MOVE;
    if (cmode[3:2] != 2'b11) begin
      if (cmode[0]) kind = opBit ? OP_ANDNOT : OP_OR;
      else          kind = opBit ? OP_MOVEINV : OP_MOVE;
    end else if (cmode[1] == 1'b0) begin
      kind = opBit ? OP_MOVEINV : OP_MOVE;
    end else begin
      kind = OP_MOVE;
    end
  end

  assign strb.capture   = inValid && !undefNow;
  assign strb.kind      = kind;
  assign strb.fullWidth = qBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resUndef <= 1'b0;
      resWrEn  <= 1'b0;
    end else begin
      resValid <= inValid;
      resUndef <= inValid && undefNow;
      resWrEn  <= inValid && !undefNow;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);
  a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !resValid);
  a_r13_wren_excl_undef: assert property (@(posedge clk) disable iff (!rstN)
    !(resWrEn && resUndef));
  a_r2_flags_need_valid: assert property (@(posedge clk) disable iff (!rstN)
    (resWrEn || resUndef) |-> resValid);
endmodule

// File: rtl/simdImmDatapath.sv
module simdImmDatapath
  import simdImmPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strb,
  input  logic [31:0]           instrWord,
  input  logic [VEC_BITS-1:0]   operand,
  output logic [VEC_BITS-1:0]   resData,
  output logic [DEST_BITS-1:0]  resDest
);
  logic [IMM_BITS-1:0] imm8;
  logic [3:0]          cmode;
  logic                opBit;
  logic [31:0]         lane32Shift;
  logic [15:0]         lane16Shift;
  logic [31:0]         lane32Ones;
  logic [31:0]         lane32Fp;
  logic [PAT_BITS-1:0] byteMask;
  logic [PAT_BITS-1:0] pattern;
  logic [VEC_BITS-1:0] replicated;
  logic [VEC_BITS-1:0] widthMask;
  logic [VEC_BITS-1:0] nextData;

  assign imm8  = {instrWord[18:16], instrWord[9:5]};
  assign cmode = instrWord[15:12];
  assign opBit = instrWord[29];

  assign lane32Shift = {24'b0, imm8} << {cmode[2:1], 3'b000};
  assign lane16Shift = {8'b0, imm8} << {cmode[1], 3'b000};
  assign lane32Ones  = cmode[0] ? {8'b0, imm8, 16'hFFFF} : {16'b0, imm8, 8'hFF};
  assign lane32Fp    = {imm8[7], ~imm8[6], {5{imm8[6]}}, imm8[5:0], 19'b0};

  for (genvar i = 0; i < BYTES; i++) begin : g_byteMask
    assign byteMask[8*i +: 8] = {8{imm8[i]}};
  end

  always_comb begin
    if (!cmode[3])                 pattern = {2{lane32Shift}};
    else if (cmode[3:2] == 2'b10)  pattern = {4{lane16Shift}};
    else if (cmode[3:1] == 3'b110) pattern = {2{lane32Ones}};
    else if (cmode == 4'hE)        pattern = opBit ? byteMask : {BYTES{imm8}};
    else if (!opBit)               pattern = {2{lane32Fp}};
    else                           pattern = {imm8[7], ~imm8[6], {8{imm8[6]}},
                                              imm8[5:0], 48'b0};
  end

  for (genvar r = 0; r < REPL; r++) begin : g_repl
    assign replicated[r*PAT_BITS +: PAT_BITS] = pattern;
    if (r == 0) begin : g_low
      assign widthMask[r*PAT_BITS +: PAT_BITS] = '1;
    end else begin : g_high
      assign widthMask[r*PAT_BITS +: PAT_BITS] = {PAT_BITS{strb.fullWidth}};
    end
  end

  always_comb begin
    unique case (strb.kind)
      OP_MOVE:    nextData = replicated & widthMask;
      OP_MOVEINV: nextData = ~replicated & widthMask;
      OP_OR:      nextData = (operand | replicated) & widthMask;
      OP_ANDNOT:  nextData = (operand & ~replicated) & widthMask;
      default:    nextData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData <= '0;
      resDest <= '0;
    end else if (strb.capture) begin
      resData <= nextData;
      resDest <= instrWord[4:0];
    end
  end

  a_r9_or_covers_operand: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.kind == OP_OR && strb.fullWidth)
      |=> ((resData | $past(operand)) == resData));
  a_r10_andnot_within_operand: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.kind == OP_ANDNOT && strb.fullWidth)
      |=> ((resData & ~$past(operand)) == '0));
  a_r12_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.fullWidth)
      |=> (resData[VEC_BITS-1:PAT_BITS] == '0));
endmodule

// File: rtl/simdImmUnit.sv
module simdImmUnit
  import simdImmPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [31:0]   instrWord,
  input  logic [127:0]  operand,
  output logic          resValid,
  output logic          resWrEn,
  output logic          resUndef,
  output logic [4:0]    resDest,
  output logic [127:0]  resData
);
  ctrlStrobes_t strb;

  simdImmCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .instrWord (instrWord),
    .strb      (strb),
    .resValid  (resValid),
    .resUndef  (resUndef),
    .resWrEn   (resWrEn)
  );

  simdImmDatapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .instrWord (instrWord),
    .operand   (operand),
    .resData   (resData),
    .resDest   (resDest)
  );

  a_r13_undef_holds_data: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resUndef) |-> $stable(resData));
endmodule

// File: tb/simdImmUnit_tb_top.sv
`timescale 1ns/1ps
module simdImmUnit_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [31:0]  instrWord;
  logic [127:0] operand;
  logic         resValid, resWrEn, resUndef;
  logic [4:0]   resDest;
  logic [127:0] resData;

  int total = 0;
  int bad = 0;
  logic [127:0] lastData;

  always #2.5 clk = ~clk;

  simdImmUnit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .operand(operand), .resValid(resValid), .resWrEn(resWrEn),
    .resUndef(resUndef), .resDest(resDest), .resData(resData)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input logic q, input logic op,
      input logic [3:0] cm, input logic [7:0] imm, input logic [4:0] rd);
    return {1'b0, q, op, 10'b0111100000, imm[7:5], cm, 2'b01, imm[4:0], rd};
  endfunction

  // Independent pattern computation from R4..R8
  function automatic logic [63:0] refPat(input logic op, input logic [3:0] cm,
      input logic [7:0] imm);
    logic [63:0] p;
    logic [31:0] w;
    logic [15:0] h;
    p = '0;
    if (cm < 4'd8) begin
      w = 32'(imm) * (32'd1 << (8 * cm[2:1]));
      p = {w, w};
    end else if (cm < 4'd12) begin
      h = 16'(imm) * (16'd1 << (8 * cm[1]));
      p = {h, h, h, h};
    end else if (cm == 4'd12) begin
      w = 32'(imm) * 32'd256 + 32'd255;
      p = {w, w};
    end else if (cm == 4'd13) begin
      w = 32'(imm) * 32'd65536 + 32'd65535;
      p = {w, w};
    end else if (cm == 4'd14) begin
      for (int i = 0; i < 8; i++)
        p[8*i +: 8] = op ? (imm[i] ? 8'hFF : 8'h00) : imm;
    end else if (!op) begin
      w = {imm[7], !imm[6], imm[6], imm[6], imm[6], imm[6], imm[6], imm[5:0], 19'd0};
      p = {w, w};
    end else begin
      p = {imm[7], !imm[6], {8{imm[6]}}, imm[5:0], 48'd0};
    end
    return p;
  endfunction

  task automatic apply(input logic [31:0] w, input logic [127:0] opnd);
    instrWord = w;
    operand = opnd;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] imms [6];
    logic [127:0] opnds [2];
    imms = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h5E};
    opnds = '{128'h0123456789ABCDEF_FEDCBA9876543210, 128'hF0F0_0F0F_AAAA_5555_C3C3_3C3C_0000_FFFF};
    rstN = 1'b0;
    inValid = 1'b0;
    instrWord = '0;
    operand = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", 128'(resValid), 128'd0);
    check("R1 reset wren", 128'(resWrEn), 128'd0);
    check("R1 reset data", resData, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    lastData = '0;

    for (int q = 0; q < 2; q++)
      for (int op = 0; op < 2; op++)
        for (int cm = 0; cm < 16; cm++)
          for (int k = 0; k < 6; k++)
            for (int n = 0; n < 2; n++) begin
              logic [63:0] p;
              logic [127:0] rep, exp;
              logic isLogic, inv, undef;
              logic [4:0] rd;
              rd = 5'((cm * 7 + k + n) % 32);
              p = refPat(op[0], cm[3:0], imms[k]);
              rep = q[0] ? {p, p} : {64'd0, p};
              undef = (cm == 15) && op[0] && !q[0];
              isLogic = (cm < 12) && cm[0];
              inv = op[0] && (cm < 14);
              if (isLogic) exp = op[0] ? (opnds[n] & ~rep) : (opnds[n] | rep);
              else exp = inv ? ~rep : rep;
              if (!q[0]) exp[127:64] = '0;
              apply(mkWord(q[0], op[0], cm[3:0], imms[k], rd), opnds[n]);
              check("R1 valid", 128'(resValid), 128'd1);
              if (undef) begin
                check("R13 undef flag", 128'(resUndef), 128'd1);
                check("R13 wren low", 128'(resWrEn), 128'd0);
                check("R13 data held", resData, lastData);
              end else begin
                check("R2 undef low", 128'(resUndef), 128'd0);
                check("R1 wren", 128'(resWrEn), 128'd1);
                check("R3 dest", 128'(resDest), 128'(rd));
                if (isLogic && !op[0]) check("R9 or", resData, exp);
                else if (isLogic) check("R10 andnot", resData, exp);
                else if (cm >= 14) check("R7 R8 pattern move", resData, exp);
                else if (cm >= 12) check("R6 R11 ones fill", resData, exp);
                else if (cm >= 8) check("R5 R11 lanes16", resData, exp);
                else check("R4 R11 lanes32", resData, exp);
                if (!q[0]) check("R12 upper zero", resData[127:64], 128'd0);
                lastData = exp;
              end
            end

    // R1: idle cycle gives no valid
    @(negedge clk);
    check("R1 idle valid", 128'(resValid), 128'd0);
    check("R1 idle wren", 128'(resWrEn), 128'd0);

    // R2: class mismatches
    begin
      logic [31:0] good;
      good = mkWord(1'b1, 1'b0, 4'h0, 8'h12, 5'd3);
      apply(good ^ 32'h8000_0000, 128'd0);
      check("R2 bit31 undef", 128'(resUndef), 128'd1);
      check("R2 bit31 wren", 128'(resWrEn), 128'd0);
      apply(good ^ 32'h0000_0400, 128'd0);
      check("R2 bit10 undef", 128'(resUndef), 128'd1);
      apply(good ^ 32'h0100_0000, 128'd0);
      check("R2 bit24 undef", 128'(resUndef), 128'd1);
      check("R2 data held", resData, lastData);
      apply(good, 128'd0);
      check("R2 good word", resData, 128'h00000012000000120000001200000012);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule